// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

The block gathers six interrupt request flags (two external pins, three timer overflows and the serial port) and decides which one the CPU services and when. Software sets a per-source enable, a global enable and two priority bits per source. Together these give each source a level from 0 to 3. Among pending, enabled sources the highest level wins. Within one level, a fixed polling order decides.

The controller tracks which levels are currently in service. A new request reaches the CPU only when its level is strictly above every level in service, so interrupts nest by level. The CPU side is a plain handshake. The block raises `irq_o` with a 3-bit vector index, and the CPU pulses `ack_i` when it takes the vector. A one-cycle `reti_i` pulse closes the innermost active level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable register (including global enable), both priority registers and all in-service bits are zero, and `irq_o`, `vec_o` and `lvl_o` are zero.
- R2: A source takes part in arbitration only when its request bit, its enable bit and the global enable are all set. Its enable bit is `cfg_wdata_i[i]` for source index i, and the global enable is `cfg_wdata_i[7]`, both written with `cfg_sel_i` = 0.
- R3: The level of source i is {high bit, low bit}. The low bit is `cfg_wdata_i[i]` written with `cfg_sel_i` = 1, and the high bit is `cfg_wdata_i[i]` written with `cfg_sel_i` = 2. A pending source of a higher level is chosen over any pending source of a lower level.
- R4: Among pending sources of the same level, the lowest index wins. Source indices are 0 external pin A, 1 timer A, 2 external pin B, 3 timer B, 4 serial port, 5 timer C.
- R5: `irq_o` is high only when the chosen level is strictly greater than the highest level in service. A request of equal or lower level is held off.
- R6: An `ack_i` pulse while `irq_o` is high sets in-service bit `insvc_o[lvl_o]` on that clock edge.
- R7: A `reti_i` pulse clears only the highest set in-service bit.
- R8: `vec_o` gives the index of the chosen source and `lvl_o` its level while `irq_o` is high. Both are zero while `irq_o` is low.
- R9: `ack_i` while `irq_o` is low has no effect on the in-service bits.
- R10: When `ack_i` and `reti_i` arrive in the same cycle, the return clears the old highest bit first, and the acknowledged level is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 enable, 1 priority low, 2 priority high |
| cfg_wdata_i | input | 8 | Write data |
| req_i | input | 6 | Source request flags, indexed as in R4 |
| ack_i | input | 1 | CPU takes the presented vector |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 3 | Vector index of chosen source |
| lvl_o | output | 2 | Level of chosen source |
| insvc_o | output | 4 | In-service bit per level |

## Verification
Arbitration is tried with requests from sources that all share one level, which isolates the polling order. It is also tried with a low-index source at a low level against a high-index source at a high level, which separates level comparison from index order. Enable patterns with the global bit cleared and then set show that a per-source bit alone does not let a request through. A chain of acknowledges climbing through levels 0 to 3, followed by returns that unwind it, shows nesting and top-bit clearing. A same-level request while that level is in service, and a simultaneous acknowledge and return, expose off-by-one errors in the strictness of the comparison and in the order of set and clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 6;
  localparam int NLVL   = 4;
  localparam int LVL_W  = $clog2(NLVL);
  localparam int VEC_W  = $clog2(NSRC);
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_PLO = 2'd1,
    SEL_PHI = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   en_o,
  output logic              gen_o,
  output logic [NSRC-1:0]   plo_o,
  output logic [NSRC-1:0]   phi_o
);
  // reserved bits are not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      gen_o <= 1'b0;
      plo_o <= '0;
      phi_o <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_EN: begin
          en_o  <= wdata_i[NSRC-1:0];
          gen_o <= wdata_i[DATA_W-1];
        end
        SEL_PLO: plo_o <= wdata_i[NSRC-1:0];
        SEL_PHI: phi_o <= wdata_i[NSRC-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  plo_i,
  input  logic [NSRC-1:0]  phi_i,
  output logic             found_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NSRC-1:0] lvl_mask [NLVL];

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign lvl_mask[l][s] = pend_i[s] && ({phi_i[s], plo_i[s]} == LVL_W'(l));
    end
  end

  logic [NSRC-1:0] win_mask;

  always_comb begin
    found_o  = 1'b0;
    lvl_o    = '0;
    win_mask = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (|lvl_mask[l]) begin
        found_o  = 1'b1;
        lvl_o    = LVL_W'(l);
        win_mask = lvl_mask[l];
      end
    end
  end

  // lowest index first within a level
  always_comb begin
    vec_o = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (win_mask[s]) vec_o = VEC_W'(s);
    end
  end
endmodule

// File: rtl/irq_insvc.sv
module irq_insvc
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [LVL_W-1:0] set_lvl_i,
  input  logic             clr_i,
  output logic [NLVL-1:0]  insvc_o,
  output logic             any_o,
  output logic [LVL_W-1:0] top_o
);
  always_comb begin
    top_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (insvc_o[l]) top_o = LVL_W'(l);
    end
  end

  assign any_o = |insvc_o;

  logic [NLVL-1:0] nxt;

  always_comb begin
    nxt = insvc_o;
    if (clr_i && any_o) nxt[top_o] = 1'b0;
    if (set_i) nxt[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) insvc_o <= '0;
    else         insvc_o <= nxt;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [NSRC-1:0]   req_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [NLVL-1:0]   insvc_o
);
  logic [NSRC-1:0]  en, plo, phi, pend;
  logic             gen, found, any;
  logic [LVL_W-1:0] best_lvl, top;
  logic [VEC_W-1:0] best_vec;

  irq_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en),
    .gen_o   (gen),
    .plo_o   (plo),
    .phi_o   (phi)
  );

  assign pend = req_i & en & {NSRC{gen}};

  irq_arbiter u_arb (
    .pend_i  (pend),
    .plo_i   (plo),
    .phi_i   (phi),
    .found_o (found),
    .lvl_o   (best_lvl),
    .vec_o   (best_vec)
  );

  assign irq_o = found && (!any || (best_lvl > top));
  assign vec_o = irq_o ? best_vec : '0;
  assign lvl_o = irq_o ? best_lvl : '0;

  irq_insvc u_isv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ack_i && irq_o),
    .set_lvl_i (best_lvl),
    .clr_i     (reti_i),
    .insvc_o   (insvc_o),
    .any_o     (any),
    .top_o     (top)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  req_i,
  input logic             ack_i,
  input logic             reti_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [LVL_W-1:0] lvl_o,
  input logic [NLVL-1:0]  insvc_o
);
  logic [NLVL-1:0] above;
  always_comb begin
    above = '0;
    for (int l = 0; l < NLVL; l++) above[l] = (LVL_W'(l) >= lvl_o);
  end

  AST_IRQ_ABOVE_INSVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((insvc_o & above) == '0)); // R5

  AST_IRQ_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> req_i[vec_o]); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_o == '0 && lvl_o == '0)); // R8

  AST_ACK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !reti_i) |=> insvc_o[$past(lvl_o)]); // R6

  AST_RETI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && insvc_o != '0) |=>
      ($countones(insvc_o) == $countones($past(insvc_o)) - 1)); // R7

  AST_ACK_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ack_i && irq_o) && !reti_i) |=> $stable(insvc_o)); // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ack_i   (ack_i),
  .reti_i  (reti_i),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .lvl_o   (lvl_o),
  .insvc_o (insvc_o)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_sel_i = 2'd3;
  logic [7:0] cfg_wdata_i = '0;
  logic [5:0] req_i = '0;
  logic       ack_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;
  logic [1:0] lvl_o;
  logic [3:0] insvc_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  irq_prio_ctrl u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_sel_i = 2'd3;
  endtask

  // lv packs six 2-bit levels, source 0 in bits 1:0
  task automatic set_levels(input logic [11:0] lv);
    logic [7:0] lo, hi;
    lo = '0; hi = '0;
    for (int s = 0; s < 6; s++) begin
      lo[s] = lv[2*s];
      hi[s] = lv[2*s+1];
    end
    wr(2'd1, lo);
    wr(2'd2, hi);
  endtask

  task automatic drive_req(input logic [5:0] r);
    @(negedge clk_i);
    req_i = r;
    #1;
  endtask

  task automatic pulse(input logic a, input logic r);
    @(negedge clk_i);
    ack_i = a; reti_i = r;
    @(negedge clk_i);
    ack_i = 1'b0; reti_i = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "irq", irq_o, 0);
    chk("R1", "insvc", insvc_o, 0);
    chk("R1", "vec", vec_o, 0);
    drive_req(6'h3f);
    chk("R1", "irq with enables cleared", irq_o, 0);
    drive_req(6'h00);
  endtask

  task automatic t_enable;
    wr(2'd0, 8'h3f);
    drive_req(6'h3f);
    chk("R2", "no global enable", irq_o, 0);
    wr(2'd0, 8'h88);
    #1;
    chk("R2", "only src3 enabled", vec_o, 3);
    chk("R2", "irq on src3", irq_o, 1);
    drive_req(6'h37);
    chk("R2", "src3 not requesting", irq_o, 0);
    wr(2'd0, 8'hbf);
    drive_req(6'h00);
  endtask

  task automatic t_level;
    set_levels(12'h000);
    drive_req(6'b100001);
    chk("R4", "same level src0 vs src5", vec_o, 0);
    set_levels(12'b11_00_00_00_00_00);
    #1;
    chk("R3", "src5 at level3 wins", vec_o, 5);
    chk("R8", "lvl_o", lvl_o, 3);
    set_levels(12'b00_10_00_10_00_00);
    drive_req(6'b010100);
    chk("R4", "src2 vs src4 at level2", vec_o, 2);
    chk("R8", "lvl_o level2", lvl_o, 2);
    drive_req(6'b000000);
    chk("R8", "idle vec", vec_o, 0);
  endtask

  task automatic t_nest;
    // src0 L0, src1 L1, src2 L2, src3 L3, src4 L1, src5 L0
    set_levels(12'b00_01_11_10_01_00);
    drive_req(6'b000001);
    chk("R8", "vec src0", vec_o, 0);
    pulse(1'b1, 1'b0);
    chk("R6", "insvc after L0 ack", insvc_o, 4'b0001);
    chk("R5", "same level held off", irq_o, 0);
    drive_req(6'b000010);
    chk("R5", "L1 preempts L0", irq_o, 1);
    pulse(1'b1, 1'b0);
    chk("R6", "insvc after L1 ack", insvc_o, 4'b0011);
    drive_req(6'b010000);
    chk("R5", "other L1 source held off", irq_o, 0);
    drive_req(6'b000100);
    chk("R8", "vec src2", vec_o, 2);
    pulse(1'b1, 1'b0);
    drive_req(6'b001000);
    chk("R8", "vec src3", vec_o, 3);
    pulse(1'b1, 1'b0);
    chk("R6", "all levels in service", insvc_o, 4'b1111);
    drive_req(6'b000000);
    pulse(1'b0, 1'b1);
    chk("R7", "reti clears L3", insvc_o, 4'b0111);
    pulse(1'b0, 1'b1);
    chk("R7", "reti clears L2", insvc_o, 4'b0011);
    pulse(1'b0, 1'b1);
    chk("R7", "reti clears L1", insvc_o, 4'b0001);
    pulse(1'b0, 1'b1);
    chk("R7", "reti clears L0", insvc_o, 4'b0000);
  endtask

  task automatic t_ack_idle;
    drive_req(6'b000000);
    pulse(1'b1, 1'b0);
    chk("R9", "ack while idle", insvc_o, 0);
    drive_req(6'b000001);
    pulse(1'b1, 1'b0);
    drive_req(6'b100000);
    chk("R5", "L0 request while L0 in service", irq_o, 0);
    pulse(1'b1, 1'b0);
    chk("R9", "ack while held off", insvc_o, 4'b0001);
  endtask

  task automatic t_ack_reti;
    drive_req(6'b000100);
    chk("R5", "L2 preempts L0", irq_o, 1);
    pulse(1'b1, 1'b1);
    chk("R10", "reti then ack", insvc_o, 4'b0100);
    drive_req(6'b000000);
    pulse(1'b0, 1'b1);
    chk("R7", "final reti", insvc_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_enable();
    t_level();
    t_nest();
    t_ack_idle();
    t_ack_reti();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule